// File: doc/BRIEF.md
# Timer Compare Match Unit

This block watches a free-running 16-bit timer and compares its count with a compare register loaded through a simple write port. When the count first equals the register, the unit carries out the action selected by a 4-bit mode code. The action can toggle, drive high or drive low an output pin. It can raise an interrupt flag without touching the pin. It can also fire a special event, which pulses a timer-reset strobe and, if the converter is enabled, an A/D start strobe.

The timer and the converter live outside the block. The surrounding logic feeds the count in and reacts to the two strobes. The interrupt flag is sticky, and software clears it by writing one to a clear input.

Top module: `cmp_match_unit`

## Requirements
- R1: In mode 4'b0010 the pin inverts on each match, and `pinOutEn` is high.
- R2: In mode 4'b1000 a match drives the pin to 1, and in mode 4'b1001 a match drives it to 0. Both modes hold `pinOutEn` high, and a repeated match leaves the level unchanged.
- R3: On the clock where the mode code changes to 4'b1000, the pin is loaded with 0. On the clock where it changes to 4'b1001, the pin is loaded with 1. This is the level opposite to the match action, and it takes precedence over a match in the same clock.
- R4: In mode 4'b1010 a match only sets the flag. `pinOutEn` is low, the pin level is unchanged and neither strobe fires.
- R5: In mode 4'b1011 a match sets the flag and produces a one-clock `timerRstPulse`. `adcStartPulse` fires in that same clock only if `adcEnable` was high at the match.
- R6: A match in any of the modes 0010, 1000, 1001, 1010 and 1011 sets `irqFlag`. The flag stays set until `flagClr` is high for a clock, and a match in that same clock wins over the clear.
- R7: Mode 4'b0000 switches the unit off. The pin goes to 0, `pinOutEn` is low, and a match sets no flag and fires no strobe.
- R8: Codes 4'b0001 and 4'b0011 are reserved. A match in them changes neither the pin nor the flag, and fires no strobe.
- R9: A match acts once, on the first clock where the timer equals the register. A timer that stays on the matching value does not act again until the two have differed for at least one clock.
- R10: `cmpWrEn` loads `cmpWrData` into the compare register at the clock edge. After reset the register, pin, flag and strobes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Current timer count |
| cmpWrEn | input | 1 | Write strobe for the compare register |
| cmpWrData | input | 16 | Compare value to load |
| modeSel | input | 4 | Action mode code |
| adcEnable | input | 1 | Allows the special event to start a conversion |
| flagClr | input | 1 | Write-one-to-clear for the interrupt flag |
| pinOut | output | 1 | Compare output level |
| pinOutEn | output | 1 | High while the block owns the pin |
| irqFlag | output | 1 | Sticky match flag |
| timerRstPulse | output | 1 | One-clock timer reset strobe |
| adcStartPulse | output | 1 | One-clock conversion start strobe |

## Verification
The compare itself is combinational, but every action is registered. The pin, the flag and the strobes therefore change at the same rising edge that first sees the timer equal to the register, while `pinOutEn` follows the mode code with no clock at all. A compare write needs one edge to load the register, so its match acts one edge later. The bench drives every input on the falling edge and samples results on the next falling edge, which is exactly one rising edge after the stimulus; after a compare write it waits one extra edge. The one-clock strobes are sampled in the clock they are due and again in the following clock to confirm they have dropped.

// File: rtl/cmp_match_pkg.sv
package cmp_match_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF     = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_RSV_A   = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_TOGGLE  = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_RSV_B   = 4'b0011;
  localparam logic [MODE_W-1:0] MODE_SET     = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLEAR   = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_IRQONLY = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_EVENT   = 4'b1011;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic forceLow;
    logic drvHigh;
    logic drvLow;
    logic toggle;
    logic setFlag;
    logic tmrRst;
    logic adcGo;
  } strobe_t;
endpackage

// File: rtl/cmp_match_ctrl.sv
module cmp_match_ctrl
  import cmp_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              eqNow,
  input  logic              adcEnable,
  output strobe_t           strobe,
  output logic              pinDrive
);
  logic              eqPrev;
  logic [MODE_W-1:0] modePrev;
  logic              matchRise;
  logic              entering;

  // eqPrev resets high so that a zero timer and a zero register do not act at once
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eqPrev   <= 1'b1;
      modePrev <= MODE_OFF;
    end else begin
      eqPrev   <= eqNow;
      modePrev <= modeSel;
    end
  end

  assign matchRise = eqNow & ~eqPrev;
  assign entering  = (modeSel != modePrev);

  always_comb begin
    strobe   = '0;
    pinDrive = 1'b0;
    unique case (modeSel)
      MODE_OFF: strobe.forceLow = 1'b1;
      MODE_TOGGLE: begin
        pinDrive       = 1'b1;
        strobe.toggle  = matchRise;
        strobe.setFlag = matchRise;
      end
      MODE_SET: begin
        pinDrive       = 1'b1;
        strobe.drvLow  = entering;
        strobe.drvHigh = matchRise & ~entering;
        strobe.setFlag = matchRise;
      end
      MODE_CLEAR: begin
        pinDrive       = 1'b1;
        strobe.drvHigh = entering;
        strobe.drvLow  = matchRise & ~entering;
        strobe.setFlag = matchRise;
      end
      MODE_IRQONLY: strobe.setFlag = matchRise;
      MODE_EVENT: begin
        strobe.setFlag = matchRise;
        strobe.tmrRst  = matchRise;
        strobe.adcGo   = matchRise & adcEnable;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmp_match_dp.sv
module cmp_match_dp
  import cmp_match_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] timerVal,
  input  logic             cmpWrEn,
  input  logic [TMR_W-1:0] cmpWrData,
  input  logic             flagClr,
  input  strobe_t          strobe,
  output logic             eqNow,
  output logic             pinOut,
  output logic             irqFlag,
  output logic             timerRstPulse,
  output logic             adcStartPulse
);
  logic [TMR_W-1:0] cmpReg;

  always_ff @(posedge clk) begin
    if (!rstN)        cmpReg <= '0;
    else if (cmpWrEn) cmpReg <= cmpWrData;
  end

  assign eqNow = (timerVal == cmpReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinOut        <= 1'b0;
      irqFlag       <= 1'b0;
      timerRstPulse <= 1'b0;
      adcStartPulse <= 1'b0;
    end else begin
      if (strobe.forceLow)     pinOut <= 1'b0;
      else if (strobe.drvHigh) pinOut <= 1'b1;
      else if (strobe.drvLow)  pinOut <= 1'b0;
      else if (strobe.toggle)  pinOut <= ~pinOut;

      if (strobe.setFlag) irqFlag <= 1'b1;
      else if (flagClr)   irqFlag <= 1'b0;

      timerRstPulse <= strobe.tmrRst;
      adcStartPulse <= strobe.adcGo;
    end
  end
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_match_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] timerVal,
  input  logic             cmpWrEn,
  input  logic [TMR_W-1:0] cmpWrData,
  input  logic [3:0]       modeSel,
  input  logic             adcEnable,
  input  logic             flagClr,
  output logic             pinOut,
  output logic             pinOutEn,
  output logic             irqFlag,
  output logic             timerRstPulse,
  output logic             adcStartPulse
);
  strobe_t strobe;
  logic    eqNow;

  cmp_match_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .eqNow    (eqNow),
    .adcEnable(adcEnable),
    .strobe   (strobe),
    .pinDrive (pinOutEn)
  );

  cmp_match_dp #(.TMR_W(TMR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .timerVal     (timerVal),
    .cmpWrEn      (cmpWrEn),
    .cmpWrData    (cmpWrData),
    .flagClr      (flagClr),
    .strobe       (strobe),
    .eqNow        (eqNow),
    .pinOut       (pinOut),
    .irqFlag      (irqFlag),
    .timerRstPulse(timerRstPulse),
    .adcStartPulse(adcStartPulse)
  );
endmodule

// File: rtl/cmp_match_chk.sv
module cmp_match_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] modeSel,
  input logic       flagClr,
  input logic       pinOut,
  input logic       irqFlag,
  input logic       timerRstPulse,
  input logic       adcStartPulse
);
  p_event_one_shot_r5: assert property (@(posedge clk) disable iff (!rstN)
    timerRstPulse |=> !timerRstPulse);

  p_adc_with_event_r5: assert property (@(posedge clk) disable iff (!rstN)
    adcStartPulse |-> timerRstPulse);

  p_event_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    timerRstPulse |-> irqFlag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqFlag) && !$past(flagClr)) |-> irqFlag);

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 4'b0000) |-> (!pinOut && !timerRstPulse && !$rose(irqFlag)));

  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 4'b0001 || $past(modeSel) == 4'b0011)
      |-> ($stable(pinOut) && !timerRstPulse && !$rose(irqFlag)));

  p_irqonly_pin_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 4'b1010) |-> ($stable(pinOut) && !timerRstPulse));
endmodule

bind cmp_match_unit cmp_match_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .modeSel      (modeSel),
  .flagClr      (flagClr),
  .pinOut       (pinOut),
  .irqFlag      (irqFlag),
  .timerRstPulse(timerRstPulse),
  .adcStartPulse(adcStartPulse)
);

// File: tb/cmp_match_unit_bench.sv
module cmp_match_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timerVal = '0;
  logic        cmpWrEn = 1'b0;
  logic [15:0] cmpWrData = '0;
  logic [3:0]  modeSel = 4'b0000;
  logic        adcEnable = 1'b0;
  logic        flagClr = 1'b0;
  logic        pinOut, pinOutEn, irqFlag, timerRstPulse, adcStartPulse;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cmp_match_unit u_cmp_match_unit (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .cmpWrEn(cmpWrEn),
    .cmpWrData(cmpWrData), .modeSel(modeSel), .adcEnable(adcEnable),
    .flagClr(flagClr), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqFlag(irqFlag),
    .timerRstPulse(timerRstPulse), .adcStartPulse(adcStartPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic load_cmp(input logic [15:0] v);
    cmpWrData = v; cmpWrEn = 1'b1; step(); cmpWrEn = 1'b0;
  endtask

  task automatic clear_flag();
    flagClr = 1'b1; step(); flagClr = 1'b0;
  endtask

  // Move the timer off and back onto the compare value: one fresh match
  task automatic hit(input logic [15:0] v);
    timerVal = v + 16'd1; step();
    timerVal = v; step();
  endtask

  task automatic t_reset();
    check("R10 reset pin", pinOut, 0);
    check("R10 reset flag", irqFlag, 0);
    check("R10 reset strobes", {timerRstPulse, adcStartPulse}, 0);
    check("R7 off enable", pinOutEn, 0);
  endtask

  task automatic t_toggle();
    modeSel = 4'b0010; timerVal = 16'd50; load_cmp(16'd100);
    check("R1 enable", pinOutEn, 1);
    timerVal = 16'd100; step();
    check("R1 first toggle", pinOut, 1);
    check("R6 flag on toggle", irqFlag, 1);
    hit(16'd100);
    check("R1 second toggle", pinOut, 0);
    clear_flag();
    check("R6 flag cleared", irqFlag, 0);
  endtask

  task automatic t_stall();
    timerVal = 16'd100; step(); step(); step(); step();
    check("R9 stalled timer no repeat", pinOut, 0);
    check("R9 stalled no flag", irqFlag, 0);
    timerVal = 16'd101; step(); timerVal = 16'd100; step();
    check("R9 rearmed after change", pinOut, 1);
    clear_flag();
  endtask

  task automatic t_set_clear();
    timerVal = 16'd7; modeSel = 4'b1000; step();
    check("R3 set entry level", pinOut, 0);
    check("R2 set enable", pinOutEn, 1);
    hit(16'd100);
    check("R2 set drives high", pinOut, 1);
    hit(16'd100);
    check("R2 set repeat holds", pinOut, 1);
    timerVal = 16'd7; modeSel = 4'b1001; step();
    check("R3 clear entry level", pinOut, 1);
    hit(16'd100);
    check("R2 clear drives low", pinOut, 0);
    clear_flag();
  endtask

  task automatic t_irq_only();
    timerVal = 16'd7; modeSel = 4'b1000; step();
    hit(16'd100);
    timerVal = 16'd7; modeSel = 4'b1010; step();
    check("R4 enable released", pinOutEn, 0);
    clear_flag();
    hit(16'd100);
    check("R4 flag set", irqFlag, 1);
    check("R4 pin unchanged", pinOut, 1);
    check("R4 no strobes", {timerRstPulse, adcStartPulse}, 0);
    clear_flag();
  endtask

  task automatic t_event();
    modeSel = 4'b1011; adcEnable = 1'b0;
    hit(16'd100);
    check("R5 timer reset pulse", timerRstPulse, 1);
    check("R5 no adc when disabled", adcStartPulse, 0);
    check("R6 flag on event", irqFlag, 1);
    timerVal = 16'd0; step();
    check("R5 pulse one clock", timerRstPulse, 0);
    adcEnable = 1'b1;
    hit(16'd100);
    check("R5 adc start when enabled", {timerRstPulse, adcStartPulse}, 2'b11);
    timerVal = 16'd0; step();
    check("R5 adc pulse one clock", adcStartPulse, 0);
    adcEnable = 1'b0;
    clear_flag();
  endtask

  task automatic t_flag_priority();
    modeSel = 4'b1010; timerVal = 16'd101; step();
    timerVal = 16'd100; flagClr = 1'b1; step(); flagClr = 1'b0;
    check("R6 set beats clear", irqFlag, 1);
    clear_flag();
  endtask

  task automatic t_reserved();
    modeSel = 4'b1000; timerVal = 16'd7; step();
    hit(16'd100); clear_flag();
    modeSel = 4'b0001; hit(16'd100);
    check("R8 code 0001 pin held", pinOut, 1);
    check("R8 code 0001 no flag", irqFlag, 0);
    modeSel = 4'b0011; hit(16'd100);
    check("R8 code 0011 quiet", {pinOut, irqFlag, timerRstPulse}, 3'b100);
  endtask

  task automatic t_off();
    modeSel = 4'b0000; timerVal = 16'd7; step();
    check("R7 pin forced low", pinOut, 0);
    check("R7 enable low", pinOutEn, 0);
    hit(16'd100);
    check("R7 no flag or strobe", {irqFlag, timerRstPulse, adcStartPulse}, 0);
  endtask

  task automatic t_cmp_write();
    modeSel = 4'b0010; timerVal = 16'd200; step();
    load_cmp(16'd200);
    check("R10 match not before load", pinOut, 0);
    step();
    check("R10 write then match", pinOut, 1);
    check("R10 write match flag", irqFlag, 1);
    clear_flag();
  endtask

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    t_reset();
    t_toggle();
    t_stall();
    t_set_clear();
    t_irq_only();
    t_event();
    t_flag_priority();
    t_reserved();
    t_off();
    t_cmp_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule